// File: doc/BRIEF.md
# SMBus block-write configuration receiver

This block is a write-only slave on a two-wire serial bus. It loads a small bank of configuration bytes from block-write frames. The bus lines SCL and SDA are oversampled by a much faster system clock. Each line passes through a two-stage synchronizer and an edge detector. START and STOP conditions are recognised from those edges, and the receiver shifts in bytes on the rising edges of SCL.

A frame has a fixed sequence:

- the 7-bit device address with a direction bit;
- a command code, whose value is not used;
- a byte count;
- up to 32 data bytes.

The data bytes always land in configuration register 0, then 1, then 2. There is no way to address a register directly. The receiver acknowledges by pulling SDA low for the ninth SCL period of each accepted byte. It never touches SCL.

The bank contents appear in parallel on one output bus. A single-cycle strobe marks the point at which a frame becomes valid, which is the end of the byte-count acknowledge. The bus timing is relative to the system clock. The only condition is that each SCL high or low phase lasts several system-clock cycles, which holds comfortably at the 100 kbit/s standard rate.

Top module: `cfgbus_blkwr_rx`

## Requirements
- R1: An address byte carrying device address 1101001 (binary) in bits 7..1, with bit 0 = 0 (write), is acknowledged. The acknowledge is `sda_oe_o` = 1 from the SCL fall after bit 0 until the SCL fall that ends the ninth clock, so SDA reads low while SCL is high in that ninth period.
- R2: An address byte with bit 0 = 1 (read), or with any other address, is not acknowledged. The rest of that frame leaves `cfg_o` and `xfer_valid_o` untouched until the next START.
- R3: The command code byte is always acknowledged, and its value has no effect on which register is written.
- R4: A byte count from 1 to 32 is acknowledged. A count of 0 or above 32 is not acknowledged, and the frame is then dropped with no register write and no valid strobe.
- R5: Data bytes are received most significant bit first. Data byte k of a frame is written to register k, with register k appearing on `cfg_o[8k+7:8k]`, for k = 0, 1, 2 in order.
- R6: `xfer_valid_o` pulses for exactly one clock when the byte-count acknowledge ends, and only for frames whose address and count were accepted.
- R7: Data bytes whose index is at or beyond the byte count, or at or beyond the three implemented registers, are acknowledged but not stored.
- R8: A STOP after any complete byte ends the frame, with the bytes so far retained. A STOP or repeated START in the middle of a byte discards that byte and leaves all registers unchanged. A repeated START begins a new address phase.
- R9: After reset `cfg_o` is all zero, `sda_oe_o` is 0 and `xfer_valid_o` is 0.
- R10: `sda_oe_o` changes only while the synchronized SCL is low, and it is released after every byte's ninth clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe_o | output | 1 | 1 pulls SDA low (acknowledge), 0 releases it |
| cfg_o | output | NUM_REGS*8 | Configuration registers, register k at bits 8k+7..8k |
| xfer_valid_o | output | 1 | One-cycle strobe when a frame's byte count is acknowledged |

## Verification
The bound checker covers the properties that hold on every cycle:

- the acknowledge driver moves only while SCL is low;
- the registers hold whenever no write is issued;
- writes never target a register that does not exist;
- the valid strobe lasts one cycle and coincides with the release of the count acknowledge.

The things only the bench's frames can show are the following:

- which address bytes are acknowledged;
- whether the byte count is accepted;
- how data bytes map onto registers in order;
- that bytes past the count or past the bank are discarded;
- that a STOP or repeated START in mid-byte leaves the stored registers intact.

// File: rtl/cfgbus_pkg.sv
package cfgbus_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RECV = 2'd1,
        ST_ACK  = 2'd2
    } rx_state_e;

    typedef enum logic [1:0] {
        FLD_ADDR = 2'd0,
        FLD_CMD  = 2'd1,
        FLD_CNT  = 2'd2,
        FLD_DATA = 2'd3
    } field_e;

endpackage

// File: rtl/cfgbus_line_sync.sv
module cfgbus_line_sync (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic line_i,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);
    typedef struct packed {
        logic [1:0] sync;
        logic       prev;
    } sync_t;

    sync_t d, q;

    always_comb begin
        d      = q;
        d.sync = {q.sync[0], line_i};
        d.prev = q.sync[1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '1;   // idle bus reads high
        else         q <= d;
    end

    assign level_o = q.sync[1];
    assign rise_o  = q.sync[1] & ~q.prev;
    assign fall_o  = ~q.sync[1] & q.prev;
endmodule

// File: rtl/cfgbus_frame_ctl.sv
module cfgbus_frame_ctl
    import cfgbus_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR  = 7'b1101001,
    parameter int         NUM_REGS  = 3,
    parameter int         MAX_COUNT = 32,
    parameter int         IDX_W     = 2,
    localparam int        CNT_W     = $clog2(MAX_COUNT + 1)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             scl_lvl_i,
    input  logic             scl_rise_i,
    input  logic             scl_fall_i,
    input  logic             sda_lvl_i,
    input  logic             sda_rise_i,
    input  logic             sda_fall_i,
    output logic             ack_o,
    output logic             wr_en_o,
    output logic [IDX_W-1:0] wr_idx_o,
    output logic [7:0]       wr_data_o,
    output logic             valid_o
);
    typedef struct packed {
        rx_state_e        state;
        field_e           field;
        logic [3:0]       bitcnt;
        logic [7:0]       shreg;
        logic             ack;
        logic [CNT_W-1:0] count;
        logic [CNT_W-1:0] didx;
        logic             wr_en;
        logic [IDX_W-1:0] wr_idx;
        logic [7:0]       wr_data;
        logic             valid;
    } ctl_t;

    ctl_t d, q;
    logic start_det, stop_det;
    logic addr_hit, count_ok, store_ok;

    assign start_det = scl_lvl_i & sda_fall_i;
    assign stop_det  = scl_lvl_i & sda_rise_i;
    assign addr_hit  = (q.shreg[7:1] == DEV_ADDR) && !q.shreg[0];
    assign count_ok  = (q.shreg != 8'd0) && (q.shreg <= 8'(MAX_COUNT));
    assign store_ok  = (q.didx < q.count) && (int'(q.didx) < NUM_REGS);

    always_comb begin
        d       = q;
        d.wr_en = 1'b0;
        d.valid = 1'b0;
        if (start_det) begin
            d.state  = ST_RECV;
            d.field  = FLD_ADDR;
            d.bitcnt = '0;
            d.ack    = 1'b0;
        end else if (stop_det) begin
            d.state = ST_IDLE;
            d.ack   = 1'b0;
        end else begin
            unique case (q.state)
                ST_RECV: begin
                    if (scl_rise_i && q.bitcnt < 4'd8) begin
                        d.shreg  = {q.shreg[6:0], sda_lvl_i};
                        d.bitcnt = q.bitcnt + 4'd1;
                    end else if (scl_fall_i && q.bitcnt == 4'd8) begin
                        d.state = ST_ACK;
                        d.ack   = 1'b1;
                        unique case (q.field)
                            FLD_ADDR: if (!addr_hit) begin
                                d.state = ST_IDLE;
                                d.ack   = 1'b0;
                            end
                            FLD_CMD: ;
                            FLD_CNT: begin
                                if (count_ok) begin
                                    d.count = CNT_W'(q.shreg);
                                end else begin
                                    d.state = ST_IDLE;
                                    d.ack   = 1'b0;
                                end
                            end
                            FLD_DATA: begin
                                if (store_ok) begin
                                    d.wr_en   = 1'b1;
                                    d.wr_idx  = q.didx[IDX_W-1:0];
                                    d.wr_data = q.shreg;
                                end
                                if (q.didx < CNT_W'(MAX_COUNT)) d.didx = q.didx + 1'b1;
                            end
                            default: ;
                        endcase
                    end
                end
                ST_ACK: begin
                    if (scl_fall_i) begin
                        d.ack    = 1'b0;
                        d.state  = ST_RECV;
                        d.bitcnt = '0;
                        unique case (q.field)
                            FLD_ADDR: d.field = FLD_CMD;
                            FLD_CMD:  d.field = FLD_CNT;
                            FLD_CNT: begin
                                d.field = FLD_DATA;
                                d.didx  = '0;
                                d.valid = 1'b1;
                            end
                            default:  d.field = FLD_DATA;
                        endcase
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q       <= '0;
            q.state <= ST_IDLE;
            q.field <= FLD_ADDR;
        end else begin
            q <= d;
        end
    end

    assign ack_o     = q.ack;
    assign wr_en_o   = q.wr_en;
    assign wr_idx_o  = q.wr_idx;
    assign wr_data_o = q.wr_data;
    assign valid_o   = q.valid;
endmodule

// File: rtl/cfgbus_reg_bank.sv
module cfgbus_reg_bank #(
    parameter int NUM_REGS = 3,
    parameter int IDX_W    = 2
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  wr_en_i,
    input  logic [IDX_W-1:0]      wr_idx_i,
    input  logic [7:0]            wr_data_i,
    output logic [NUM_REGS*8-1:0] regs_o
);
    for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
        logic [7:0] reg_d, reg_q;

        always_comb begin
            reg_d = reg_q;
            if (wr_en_i && (int'(wr_idx_i) == k)) reg_d = wr_data_i;
        end

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) reg_q <= '0;
            else         reg_q <= reg_d;
        end

        assign regs_o[8*k +: 8] = reg_q;
    end
endmodule

// File: rtl/cfgbus_blkwr_rx.sv
module cfgbus_blkwr_rx #(
    parameter logic [6:0] DEV_ADDR  = 7'b1101001,
    parameter int         NUM_REGS  = 3,
    parameter int         MAX_COUNT = 32,
    localparam int        IDX_W     = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_oe_o,
    output logic [NUM_REGS*8-1:0] cfg_o,
    output logic                  xfer_valid_o
);
    logic scl_lvl, scl_rise, scl_fall;
    logic sda_lvl, sda_rise, sda_fall;
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;
    logic [7:0]       wr_data;

    cfgbus_line_sync u_scl_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .line_i (scl_i),
        .level_o(scl_lvl),
        .rise_o (scl_rise),
        .fall_o (scl_fall)
    );

    cfgbus_line_sync u_sda_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .line_i (sda_i),
        .level_o(sda_lvl),
        .rise_o (sda_rise),
        .fall_o (sda_fall)
    );

    cfgbus_frame_ctl #(
        .DEV_ADDR (DEV_ADDR),
        .NUM_REGS (NUM_REGS),
        .MAX_COUNT(MAX_COUNT),
        .IDX_W    (IDX_W)
    ) u_ctl (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .scl_lvl_i (scl_lvl),
        .scl_rise_i(scl_rise),
        .scl_fall_i(scl_fall),
        .sda_lvl_i (sda_lvl),
        .sda_rise_i(sda_rise),
        .sda_fall_i(sda_fall),
        .ack_o     (sda_oe_o),
        .wr_en_o   (wr_en),
        .wr_idx_o  (wr_idx),
        .wr_data_o (wr_data),
        .valid_o   (xfer_valid_o)
    );

    cfgbus_reg_bank #(
        .NUM_REGS(NUM_REGS),
        .IDX_W   (IDX_W)
    ) u_bank (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .wr_en_i  (wr_en),
        .wr_idx_i (wr_idx),
        .wr_data_i(wr_data),
        .regs_o   (cfg_o)
    );
endmodule

// File: rtl/cfgbus_blkwr_rx_chk.sv
module cfgbus_blkwr_rx_chk #(
    parameter int NUM_REGS = 3,
    parameter int IDX_W    = 2
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  scl_lvl,
    input logic                  sda_oe,
    input logic                  valid,
    input logic [NUM_REGS*8-1:0] cfg,
    input logic                  wr_en,
    input logic [IDX_W-1:0]      wr_idx
);
    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);                                                    // R6

    AST_VALID_AT_ACK_END: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> ($past(sda_oe) && !sda_oe));                                // R6

    AST_ACK_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_lvl);                                       // R10

    AST_REGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(cfg));                                             // R8

    AST_WRITE_IN_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (int'(wr_idx) < NUM_REGS));                                 // R7
endmodule

bind cfgbus_blkwr_rx cfgbus_blkwr_rx_chk #(
    .NUM_REGS(NUM_REGS),
    .IDX_W   (IDX_W)
) u_chk (
    .clk    (clk_i),
    .rst_n  (rst_ni),
    .scl_lvl(scl_lvl),
    .sda_oe (sda_oe_o),
    .valid  (xfer_valid_o),
    .cfg    (cfg_o),
    .wr_en  (wr_en),
    .wr_idx (wr_idx)
);

// File: tb/sim_cfgbus_blkwr_rx.sv
`timescale 1ns/1ps
module sim_cfgbus_blkwr_rx;
    localparam int Q = 6;                 // system clocks per quarter SCL period
    localparam logic [6:0] MY_ADDR = 7'b1101001;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_bus;
    logic sda_oe;
    logic [23:0] cfg;
    logic valid;

    int n_vec = 0;
    int n_bad = 0;
    int vcnt = 0;
    int exp_v = 0;
    logic [7:0] exp_reg [3];
    bit done = 0;

    always #2.5 clk = ~clk;
    assign sda_bus = sda_m & ~sda_oe;

    cfgbus_blkwr_rx u0 (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .scl_i       (scl_m),
        .sda_i       (sda_bus),
        .sda_oe_o    (sda_oe),
        .cfg_o       (cfg),
        .xfer_valid_o(valid)
    );

    always @(posedge clk) if (rst_n && valid) vcnt <= vcnt + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
    endtask

    task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string req);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        sda_m = 1'b1; wq();
        chk(sda_oe == exp_ack, req, sda_oe, exp_ack);
        scl_m = 1'b1; wq();
        chk(sda_bus == !exp_ack, req, sda_bus, !exp_ack);
        wq(); scl_m = 1'b0; wq();
        chk(sda_oe == 1'b0, "R10 release", sda_oe, 0);
    endtask

    function automatic logic [23:0] exp_cfg();
        return {exp_reg[2], exp_reg[1], exp_reg[0]};
    endfunction

    // one full frame; nbytes data bytes sent regardless of count
    task automatic frame(input logic [6:0] a, input logic rw, input logic [7:0] cmd,
                         input logic [7:0] cnt, input int nbytes, input logic [7:0] base,
                         input string req);
        bit a_ok;
        bit c_ok;
        logic [7:0] dv;
        a_ok = (a == MY_ADDR) && !rw;
        c_ok = (cnt >= 1) && (cnt <= 32);
        bus_start();
        send_byte({a, rw}, a_ok, "R1/R2 address");
        if (a_ok) begin
            send_byte(cmd, 1'b1, "R3 command");
            send_byte(cnt, c_ok, "R4 count");
            if (c_ok) exp_v++;
            for (int k = 0; k < nbytes; k++) begin
                dv = base ^ 8'(k * 8'h35);
                send_byte(dv, c_ok, "R7 data ack");
                if (c_ok && k < int'(cnt) && k < 3) exp_reg[k] = dv;
            end
        end
        bus_stop();
        wq();
        chk(cfg == exp_cfg(), req, cfg, exp_cfg());
        chk(vcnt == exp_v, "R6 valid count", vcnt, exp_v);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 3; k++) exp_reg[k] = 8'h00;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        wq();
        // R9 reset state
        chk(cfg == 24'h0, "R9 cfg", cfg, 0);
        chk(sda_oe == 1'b0, "R9 sda_oe", sda_oe, 0);
        chk(valid == 1'b0, "R9 valid", valid, 0);

        // R1 R5 basic frame, MSB-first bytes into regs 0..2
        frame(MY_ADDR, 1'b0, 8'h00, 8'd3, 3, 8'hA5, "R5 basic frame");

        // R3 R7 sweep count 1..6 with 5 data bytes and varying command codes
        for (int n = 1; n <= 6; n++)
            frame(MY_ADDR, 1'b0, 8'(n * 37), 8'(n), 5, 8'(n * 16 + 3), "R7 count sweep");

        // R4 illegal and edge counts
        frame(MY_ADDR, 1'b0, 8'h00, 8'd0, 2, 8'h11, "R4 count zero");
        frame(MY_ADDR, 1'b0, 8'h00, 8'd33, 2, 8'h22, "R4 count 33");
        frame(MY_ADDR, 1'b0, 8'h00, 8'd32, 4, 8'h5C, "R4 count 32");

        // R2 read direction and wrong addresses with full frames
        frame(MY_ADDR, 1'b1, 8'h00, 8'd3, 3, 8'hE7, "R2 read refused");
        frame(7'b1101000, 1'b0, 8'h00, 8'd3, 3, 8'h18, "R2 wrong address");
        frame(7'b0000000, 1'b0, 8'h00, 8'd3, 3, 8'h29, "R2 general call");

        // R1 R2 address sweep, write direction
        for (int a = 0; a < 128; a++) begin
            bus_start();
            send_byte({7'(a), 1'b0}, (7'(a) == MY_ADDR), "R1/R2 address sweep");
            bus_stop();
        end
        wq();
        chk(cfg == exp_cfg(), "R2 regs after sweep", cfg, exp_cfg());
        chk(vcnt == exp_v, "R2 no valid in sweep", vcnt, exp_v);

        // R8 STOP after one complete data byte, then STOP mid-byte
        bus_start();
        send_byte({MY_ADDR, 1'b0}, 1'b1, "R1 address");
        send_byte(8'h00, 1'b1, "R3 command");
        send_byte(8'd3, 1'b1, "R4 count");
        exp_v++;
        send_byte(8'h96, 1'b1, "R8 data");
        exp_reg[0] = 8'h96;
        for (int i = 0; i < 4; i++) send_bit(1'b1);
        bus_stop();
        wq();
        chk(cfg == exp_cfg(), "R8 stop mid-byte", cfg, exp_cfg());

        // R8 repeated START mid-byte then a fresh frame
        bus_start();
        send_byte({MY_ADDR, 1'b0}, 1'b1, "R1 address");
        send_byte(8'h00, 1'b1, "R3 command");
        send_byte(8'd2, 1'b1, "R4 count");
        exp_v++;
        for (int i = 0; i < 3; i++) send_bit(1'b0);
        wq();
        chk(cfg == exp_cfg(), "R8 restart mid-byte", cfg, exp_cfg());
        frame(MY_ADDR, 1'b0, 8'h00, 8'd2, 2, 8'h3B, "R8 frame after restart");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule